// File: doc/BRIEF.md
# Pulse Period and High-Time Capture with Edge Prescaler

This block measures an external pulse train. A free-running timebase counts divided clock ticks. Two capture channels watch the same synchronized input. The rise channel records the count on rising edges and then restarts the timebase, so each rise value is the elapsed count between two recorded rising edges. The fall channel records the count reached since the last recorded rising edge.

A shared 2-bit edge-division code lets each channel record only every 1st, 2nd, 4th or 8th qualifying edge. This spreads a fast period over several input cycles so that it can be measured more precisely. Each recorded capture raises a one-cycle request pulse for a data mover, and sets a flag that software clears with a read strobe. A capture that lands on a flag that is still set raises an overcapture flag.

The request pulses are plain strobes with no back-pressure. A consumer that misses one loses it, and the overcapture flag is the only record of that loss. Conversion of counts into time units is left to software.

Top module: `pwm_capture_top`

## Requirements
- R1: The input passes through two synchronizer flops and an edge detector. A level change driven before clock edge E0 is captured, and its request shows, at the third rising clock edge (E2).
- R2: The timebase advances once every `clk_div`+1 clock cycles, and both the count and the divider restart on each recorded rising capture. With code p, clock divide d and input period P cycles, `rise_cap` reads floor(2^p·P/(d+1)) in steady state.
- R3: When capture is enabled while the input is low, `fall_cap` reads floor(H/(d+1)), where H is the high time in cycles.
- R4: With code p (0,1,2,3), a channel records on every 2^p-th qualifying edge counted from enable. Over 16 input periods each channel therefore issues 16/2^p requests.
- R5: Each recorded capture gives exactly one request pulse, one cycle wide, in the same cycle as the capture register updates.
- R6: When capture is enabled while the input is high, the edge counters are out of phase and `fall_cap` reads floor(((2^p−1)·P+H)/(d+1)). With d=0, (`rise_cap`>>p) − (`rise_cap` − `fall_cap`) equals H.
- R7: Changing `edge_psc` clears both edge counters. The next record then takes 2^p fresh edges.
- R8: While `cap_en` is low, no request is raised and both capture registers hold their values.
- R9: A capture sets its channel's flag. A read strobe clears the flag and the overcapture flag, unless a capture occurs in the same cycle.
- R10: All outputs are zero after reset. A capture that occurs while the flag is set, with no read strobe in that cycle, sets the overcapture flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pulse_in | input | 1 | Asynchronous pulse input |
| cap_en | input | 1 | Capture enable; low clears the timebase and the edge counters |
| edge_psc | input | 2 | Edge division code shared by both channels (0:1, 1:2, 2:4, 3:8) |
| clk_div | input | 16 | Timebase divide value; the timebase ticks every value+1 cycles |
| rd_rise | input | 1 | Read strobe that clears the rise flags |
| rd_fall | input | 1 | Read strobe that clears the fall flags |
| rise_cap | output | 16 | Count recorded at the last prescaled rising edge |
| fall_cap | output | 16 | Count recorded at the last prescaled falling edge |
| rise_flag | output | 1 | Rise capture pending |
| fall_flag | output | 1 | Fall capture pending |
| rise_ovr | output | 1 | Rise capture overwritten before it was read |
| fall_ovr | output | 1 | Fall capture overwritten before it was read |
| rise_req | output | 1 | One-cycle request per rise capture |
| fall_req | output | 1 | One-cycle request per fall capture |

## Verification
Every result of an input change is due at the third rising clock edge after the change is driven: the two synchronizer flops, then the capture register. Request, capture value and flag all update at that same edge.

The bench drives inputs at falling edges and samples at the following falling edges, so a request is expected on the third sample after the change, and the directed test checks the samples on either side of it. Interval values do not depend on this fixed latency. The sweep compares the last recorded values after eight trailing cycles, which leaves room for the final edge to propagate. Flag effects of a read strobe are checked one sample after the strobe.

// File: rtl/pwm_cap_pkg.sv
package pwm_cap_pkg;
  localparam int CODE_W     = 2;
  localparam int EDGE_CNT_W = (1 << CODE_W) - 1;
  localparam int N_CH       = 2;
  localparam int CH_RISE    = 0;
  localparam int CH_FALL    = 1;

  typedef logic [CODE_W-1:0]     edge_code_t;
  typedef logic [EDGE_CNT_W-1:0] edge_cnt_t;

  // wrap value of the edge counter: 2^code - 1
  function automatic edge_cnt_t edge_mask(edge_code_t code);
    edge_cnt_t m;
    m = '0;
    for (int i = 0; i < EDGE_CNT_W; i++) begin
      if (i < int'(code)) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pwm_cap_sync.sv
module pwm_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_det,
  output logic fall_det
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_det = sh_q[STAGES-1] & ~prev_q;
  assign fall_det = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pwm_cap_timebase.sv
module pwm_cap_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PSC_W-1:0] div,
  output logic [CNT_W-1:0] cnt_now
);
  logic [PSC_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick    = (div_q >= div);
  // value the count reaches at this edge, tick included
  assign cnt_now = cnt_q + {{(CNT_W-1){1'b0}}, tick};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + PSC_W'(1);
      cnt_q <= cnt_now;
    end
  end
endmodule

// File: rtl/pwm_cap_edge_div.sv
module pwm_cap_edge_div
  import pwm_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  edge_code_t code,
  input  logic       edge_in,
  output logic       fire
);
  edge_cnt_t  cnt_q;
  edge_code_t code_q;
  edge_cnt_t  wrap;
  logic       restart;

  assign wrap    = edge_mask(code);
  assign restart = !en || (code != code_q);
  assign fire    = edge_in && !restart && (cnt_q == wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      code_q <= code;
      if (restart)      cnt_q <= '0;
      else if (edge_in) cnt_q <= (cnt_q == wrap) ? '0 : cnt_q + EDGE_CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_capture_top.sv
module pwm_capture_top
  import pwm_cap_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             cap_en,
  input  logic [1:0]       edge_psc,
  input  logic [PSC_W-1:0] clk_div,
  input  logic             rd_rise,
  input  logic             rd_fall,
  output logic [CNT_W-1:0] rise_cap,
  output logic [CNT_W-1:0] fall_cap,
  output logic             rise_flag,
  output logic             fall_flag,
  output logic             rise_ovr,
  output logic             fall_ovr,
  output logic             rise_req,
  output logic             fall_req
);
  logic [N_CH-1:0] edge_det;
  logic [N_CH-1:0] fire;
  logic [N_CH-1:0] rd_clr;
  logic [N_CH-1:0] req_q, flag_q, ovr_q;
  logic [CNT_W-1:0] cap_q [N_CH];
  logic [CNT_W-1:0] cnt_now;

  pwm_cap_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (pulse_in),
    .rise_det (edge_det[CH_RISE]),
    .fall_det (edge_det[CH_FALL])
  );

  // timebase restarts on every recorded rising capture
  pwm_cap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!cap_en || fire[CH_RISE]),
    .div     (clk_div),
    .cnt_now (cnt_now)
  );

  assign rd_clr[CH_RISE] = rd_rise;
  assign rd_clr[CH_FALL] = rd_fall;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm_cap_edge_div u_ediv (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cap_en),
      .code    (edge_psc),
      .edge_in (edge_det[g]),
      .fire    (fire[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q[g]  <= '0;
        req_q[g]  <= 1'b0;
        flag_q[g] <= 1'b0;
        ovr_q[g]  <= 1'b0;
      end else begin
        req_q[g] <= fire[g];
        if (fire[g]) begin
          cap_q[g]  <= cnt_now;
          flag_q[g] <= 1'b1;
          ovr_q[g]  <= flag_q[g] & ~rd_clr[g];
        end else if (rd_clr[g]) begin
          flag_q[g] <= 1'b0;
          ovr_q[g]  <= 1'b0;
        end
      end
    end
  end

  assign rise_cap  = cap_q[CH_RISE];
  assign fall_cap  = cap_q[CH_FALL];
  assign rise_req  = req_q[CH_RISE];
  assign fall_req  = req_q[CH_FALL];
  assign rise_flag = flag_q[CH_RISE];
  assign fall_flag = flag_q[CH_FALL];
  assign rise_ovr  = ovr_q[CH_RISE];
  assign fall_ovr  = ovr_q[CH_FALL];
endmodule

// File: rtl/pwm_capture_chk.sv
module pwm_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_en,
  input logic             rd_rise,
  input logic [CNT_W-1:0] rise_cap,
  input logic [CNT_W-1:0] fall_cap,
  input logic             rise_flag,
  input logic             rise_ovr,
  input logic             rise_req,
  input logic             fall_req
);
  // R5: requests last one cycle
  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_req |=> !rise_req);
  p_fall_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_req |=> !fall_req);

  // R8: capture registers move only with a request; none while disabled
  p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_req |-> $stable(rise_cap));
  p_fcap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_req |-> $stable(fall_cap));
  p_idle_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> (!rise_req && !fall_req));

  // R9: a capture leaves the flag set, a read clears it
  p_flag_on_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_req |-> rise_flag);
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> (!rise_flag || rise_req));

  // R10: overcapture only rises on a capture over a pending flag
  p_ovr_after_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rise_ovr) |-> (rise_req && $past(rise_flag)));
endmodule

bind pwm_capture_top pwm_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_en    (cap_en),
  .rd_rise   (rd_rise),
  .rise_cap  (rise_cap),
  .fall_cap  (fall_cap),
  .rise_flag (rise_flag),
  .rise_ovr  (rise_ovr),
  .rise_req  (rise_req),
  .fall_req  (fall_req)
);

// File: tb/pwm_capture_top_tb_top.sv
module pwm_capture_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_in = 1'b0;
  logic        cap_en = 1'b0;
  logic [1:0]  edge_psc = 2'd0;
  logic [15:0] clk_div = 16'd0;
  logic        rd_rise = 1'b0;
  logic        rd_fall = 1'b0;
  logic [15:0] rise_cap, fall_cap;
  logic        rise_flag, fall_flag, rise_ovr, fall_ovr, rise_req, fall_req;

  int n_chk = 0;
  int n_bad = 0;
  int rcnt = 0;
  int fcnt = 0;
  int rlast = 0;
  int flast = 0;
  bit auto_rd = 1'b1;

  always #5 clk = ~clk;

  pwm_capture_top dut_i (
    .clk (clk), .rst_n (rst_n), .pulse_in (pulse_in), .cap_en (cap_en),
    .edge_psc (edge_psc), .clk_div (clk_div), .rd_rise (rd_rise), .rd_fall (rd_fall),
    .rise_cap (rise_cap), .fall_cap (fall_cap), .rise_flag (rise_flag),
    .fall_flag (fall_flag), .rise_ovr (rise_ovr), .fall_ovr (fall_ovr),
    .rise_req (rise_req), .fall_req (fall_req)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rise_req) begin rcnt++; rlast = int'(rise_cap); end
    if (fall_req) begin fcnt++; flast = int'(fall_cap); end
    rd_rise = auto_rd & rise_req;
    rd_fall = auto_rd & fall_req;
  endtask

  task automatic hold(input int n);
    repeat (n) step();
  endtask

  task automatic pulse(input int hi_len, input int lo_len);
    pulse_in = 1'b1; hold(hi_len);
    pulse_in = 1'b0; hold(lo_len);
  endtask

  task automatic run_case(input int p, input int d, input int per, input int hi, input bit start_high);
    int lo;
    lo = per - hi;
    cap_en = 1'b0; auto_rd = 1'b1;
    pulse_in = start_high; edge_psc = 2'(p); clk_div = 16'(d);
    hold(6);
    rcnt = 0; fcnt = 0;
    cap_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      hold(start_high ? hi : lo); pulse_in = ~pulse_in;
      hold(start_high ? lo : hi); pulse_in = ~pulse_in;
    end
    hold(8);
    chk("R4 rise request count", rcnt, 16 >> p);
    chk("R4 fall request count", fcnt, 16 >> p);
    chk("R2 rise capture", rlast, (per << p) / (d + 1));
    if (start_high) begin
      chk("R6 offset fall capture", flast, (((1 << p) - 1) * per + hi) / (d + 1));
      if (d == 0) chk("R6 corrected high time", (rlast >> p) - (rlast - flast), hi);
    end else begin
      chk("R3 fall capture", flast, hi / (d + 1));
    end
    chk("R9 no overcapture when read", rise_ovr | fall_ovr, 0);
    cap_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset values
    chk("R10 reset rise_cap", rise_cap, 0);
    chk("R10 reset fall_cap", fall_cap, 0);
    chk("R10 reset flags", {rise_flag, fall_flag, rise_ovr, fall_ovr}, 0);
    chk("R10 reset requests", {rise_req, fall_req}, 0);

    // R1/R5: request due on the third sample after the change
    edge_psc = 2'd0; clk_div = 16'd0; auto_rd = 1'b1;
    hold(4); cap_en = 1'b1; hold(6);
    pulse_in = 1'b1;
    step(); chk("R1 no request after 1 edge", rise_req, 0);
    step(); chk("R1 no request after 2 edges", rise_req, 0);
    step(); chk("R1 request at third edge", rise_req, 1);
    chk("R9 flag set with capture", rise_flag, 1);
    step(); chk("R5 request one cycle wide", rise_req, 0);
    pulse_in = 1'b0; hold(6);
    cap_en = 1'b0;

    // sweep of codes, start levels and waveforms
    for (int p = 0; p < 4; p++) begin
      for (int sh = 0; sh < 2; sh++) begin
        run_case(p, 0, 10, 3, sh[0]);
        run_case(p, 0, 7, 5, sh[0]);
      end
    end
    // R2 with a divided timebase
    run_case(1, 2, 12, 6, 1'b0);
    run_case(1, 2, 12, 6, 1'b1);
    run_case(3, 3, 9, 4, 1'b0);

    // R7: code change clears the edge counters
    cap_en = 1'b0; pulse_in = 1'b0; edge_psc = 2'd1; clk_div = 16'd0; auto_rd = 1'b1;
    hold(6); cap_en = 1'b1; rcnt = 0;
    pulse(5, 5);
    chk("R7 one edge under code 1", rcnt, 0);
    edge_psc = 2'd2; hold(3);
    pulse(5, 5); pulse(5, 5); pulse(5, 5);
    chk("R7 three edges after change", rcnt, 0);
    pulse(5, 5);
    chk("R7 fourth edge after change", rcnt, 1);

    // R8: disabled input is ignored
    cap_en = 1'b0; hold(6);
    begin
      int r0, f0;
      r0 = int'(rise_cap); f0 = int'(fall_cap);
      rcnt = 0; fcnt = 0;
      for (int i = 0; i < 4; i++) pulse(4, 4);
      hold(6);
      chk("R8 no requests while disabled", rcnt + fcnt, 0);
      chk("R8 rise_cap held", rise_cap, r0);
      chk("R8 fall_cap held", fall_cap, f0);
    end

    // R9/R10: flags and overcapture
    edge_psc = 2'd0; auto_rd = 1'b0;
    hold(2); cap_en = 1'b1; hold(6);
    pulse(5, 5);
    chk("R9 rise flag set", rise_flag, 1);
    chk("R9 fall flag set", fall_flag, 1);
    chk("R10 no overcapture yet", rise_ovr, 0);
    pulse(5, 5);
    chk("R10 rise overcapture", rise_ovr, 1);
    chk("R10 fall overcapture", fall_ovr, 1);
    rd_rise = 1'b1; rd_fall = 1'b1;
    step();
    chk("R9 read clears rise flags", {rise_flag, rise_ovr}, 0);
    chk("R9 read clears fall flags", {fall_flag, fall_ovr}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule